// File: doc/BRIEF.md
# Smart card character UART

This block is the character layer of a smart card reader interface. It moves single bytes across one shared, open-drain data line: it pulls the line low or lets it float and never drives it high. All timing is counted in elementary time units (ETU). The ETU length is set in eighths of a card clock cycle, so lengths such as 11.625 clocks are exact over a whole character.

The host hands over a byte with `tx_valid`/`tx_ready` and receives bytes as single-cycle `rx_valid` pulses. A frame has a low start bit, eight data bits and an even parity bit. Direct convention sends the least significant bit first with high meaning one. Inverse convention sends the most significant bit first with every level inverted, the parity bit included. In the character protocol with error signalling (`cfg_t1`=0), the receiver flags a parity error by pulling the line low. The transmitter watches for that flag and repeats the character, up to a configured limit. In the block protocol (`cfg_t1`=1), a parity error is only reported. A guard counter sets the minimum spacing between transmitted characters, and a waiting-time counter flags silence on the line.

The control state machine has five states. IDLE waits for work. TX_BITS drives the ten frame bits. TX_HOLD covers the guard time and the error-flag sample. RX_BITS qualifies the start bit and samples the frame. RX_ERR pulls the line low to flag a parity error.

Its transitions are:
- accept: IDLE to TX_BITS.
- start_edge: IDLE to RX_BITS.
- bits_done: TX_BITS to TX_HOLD.
- repeat: TX_HOLD to TX_BITS.
- hold_done: TX_HOLD to IDLE.
- glitch: RX_BITS to IDLE.
- rx_done: RX_BITS to IDLE.
- flag_error: RX_BITS to RX_ERR.
- flag_done: RX_ERR to IDLE.

Top module: `sc_char_uart`

## Requirements
- R1: The ETU is `cfg_etu_div`/8 card clock cycles, and a half ETU is `cfg_etu_div`/16 cycles, with the fraction carried from one half ETU to the next. The line is released at the first clock edge at or after 10 ETU from the accept edge. For `cfg_etu_div`=93 and byte 0x00 this is 117 cycles; for 128 it is 160 cycles.
- R2: The transmitter works as follows when `cfg_inverse`=0:
  - The cycle after accept, it drives the start bit low.
  - It then sends data bit 0 first through data bit 7 last, with a one released and a zero driven low.
  - It then sends the even parity bit.
  - Each bit lasts 1 ETU. After 10 ETU the line is released.
- R3: With `cfg_inverse`=1, the data goes most significant bit first and every data and parity level is inverted; the start bit stays low. The receiver decodes the same way.
- R4: Two transmitted characters start at least max(`cfg_guard`, 12) ETU apart, and no more than two cycles beyond that.
- R5: With `cfg_t1`=0, the transmitter samples the line at 11 ETU and handles a low sample as an error flag:
  - It repeats the character once the line is high again at or after the guard end.
  - It makes at most `cfg_retry_max` repeats.
  - Once the repeats are used up, it sets `tx_fail`. `tx_fail` clears on the next accept.
- R6: The receiver handles a character as follows:
  - A falling line in IDLE starts a reception.
  - If the line is high again at 0.5 ETU, the reception is dropped and nothing is reported.
  - Bits are sampled at the middle of each ETU.
  - A character with good parity gives one `rx_valid` pulse carrying the byte and `rx_perr`=0.
- R7: With `cfg_t1`=0, a received parity error makes the block pull the line low from 10.5 to 12 ETU after the start edge, and no `rx_valid` pulse is given.
- R8: With `cfg_t1`=1, a received parity error gives `rx_valid` with `rx_perr`=1, and the line is not driven.
- R9: `wt_timeout` goes high once the number of whole ETUs since the last frame start reaches `cfg_wt_limit`. It clears at the next frame start. A limit of 0 disables it.
- R10: After reset the line is released, `tx_ready` is 1, and `rx_valid`, `tx_fail` and `wt_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock domain clock |
| rst_n | input | 1 | Active-low reset |
| cfg_etu_div | input | 12 | ETU length in eighths of a clock |
| cfg_inverse | input | 1 | 1 = inverse convention |
| cfg_t1 | input | 1 | 1 = no error signalling or repetition |
| cfg_guard | input | 16 | Minimum ETUs between transmit starts |
| cfg_retry_max | input | 3 | Maximum number of repeats |
| cfg_wt_limit | input | 32 | Waiting time limit in ETU, 0 = off |
| io_in | input | 1 | Sensed level of the shared line |
| io_drive_low | output | 1 | 1 = pull the line low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Send request |
| tx_ready | output | 1 | Ready to accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle received-byte strobe |
| rx_perr | output | 1 | Parity error on the received byte |
| tx_fail | output | 1 | Repeats used up |
| wt_timeout | output | 1 | Waiting time reached |

## Verification
The hardest case to reach is the repeat path. The line must be low at exactly the 11 ETU sample, and it must still be low past the guard end so that the restart waits for the line to go high. The bench plays the card. It pulls the line from 10.5 to 12 ETU of every frame the block sends, and counts the start bits that follow until `tx_ready` comes back. It does this for three cases: a flag on every frame with a limit of two, a limit of zero, and a flag on the first frame only. A second hard case is the fractional divider. It is checked by timing the release edge of an all-zero frame at an ETU of 11.625 clocks, where only accumulated eighths give the right cycle.

// File: rtl/sc_uart_pkg.sv
`timescale 1ns/1ps
package sc_uart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_BITS,
        ST_TX_HOLD,
        ST_RX_BITS,
        ST_RX_ERR
    } sc_state_t;

    localparam int MIN_GUARD_ETU = 12;

    // Line levels of one frame: [0] start, [8:1] data in wire order, [9] parity
    function automatic logic [9:0] encode_frame(input logic [7:0] b, input logic inv);
        logic [7:0] ord;
        logic [8:0] lv;
        for (int i = 0; i < 8; i++) ord[i] = inv ? b[7-i] : b[i];
        lv = {^b, ord};
        if (inv) lv = ~lv;
        return {lv, 1'b0};
    endfunction

    // Samples in wire order ([8] = parity sample) -> {byte, parity_error}
    function automatic logic [8:0] decode_frame(input logic [8:0] s, input logic inv);
        logic [8:0] lg;
        logic [7:0] b;
        lg = inv ? ~s : s;
        for (int i = 0; i < 8; i++) b[i] = inv ? lg[7-i] : lg[i];
        return {b, ^lg};
    endfunction

endpackage

// File: rtl/sc_etu_div.sv
`timescale 1ns/1ps
module sc_etu_div #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(16);

    logic [ACC_W-1:0] acc_q, sum;

    assign sum       = acc_q + STEP;
    assign half_tick = (sum >= {1'b0, div});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         acc_q <= '0;
        else if (restart)   acc_q <= '0;
        else if (half_tick) acc_q <= sum - {1'b0, div};
        else                acc_q <= sum;
    end

    AST_HALF_GAP: assert property (@(posedge clk) disable iff (!rst_n || div < DIV_W'(32))
        half_tick |=> !half_tick) else $error("half ticks too close"); // R1

endmodule

// File: rtl/sc_wait_timer.sv
`timescale 1ns/1ps
module sc_wait_timer #(
    parameter int WT_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            half_tick,
    input  logic [WT_W-1:0] limit,
    output logic            timeout
);
    logic            phase_q;
    logic [WT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (restart) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (half_tick) begin
            phase_q <= ~phase_q;
            if (phase_q && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout = (limit != '0) && (cnt_q >= limit);

    AST_WT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !restart && limit == $past(limit)) |=> timeout) else $error("timeout dropped"); // R9

endmodule

// File: rtl/sc_char_uart.sv
`timescale 1ns/1ps
module sc_char_uart
    import sc_uart_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int GT_W    = 16,
    parameter int WT_W    = 32,
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cfg_etu_div,
    input  logic               cfg_inverse,
    input  logic               cfg_t1,
    input  logic [GT_W-1:0]    cfg_guard,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [WT_W-1:0]    cfg_wt_limit,
    input  logic               io_in,
    output logic               io_drive_low,
    input  logic [7:0]         tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    output logic               rx_perr,
    output logic               tx_fail,
    output logic               wt_timeout
);
    localparam int H_W = GT_W + 2;
    localparam logic [H_W-1:0] H_QUAL    = H_W'(1);
    localparam logic [H_W-1:0] H_SMP_LO  = H_W'(3);
    localparam logic [H_W-1:0] H_SMP_HI  = H_W'(19);
    localparam logic [H_W-1:0] H_TX_END  = H_W'(20);
    localparam logic [H_W-1:0] H_RX_END  = H_W'(21);
    localparam logic [H_W-1:0] H_CHK     = H_W'(22);
    localparam logic [H_W-1:0] H_ERR_END = H_W'(24);

    sc_state_t state_q, state_d;
    logic [H_W-1:0]     h_q, h_d, hn, hold_end;
    logic [9:0]         frame_q, frame_d;
    logic [RETRY_W-1:0] retry_q, retry_d;
    logic               fail_q, fail_d, rep_q, rep_d;
    logic               half_tick, div_restart, rx_fire;
    logic [8:0]         dec;
    logic [15:0]        frame_ext;
    logic [GT_W-1:0]    guard_eff;

    sc_etu_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(div_restart),
        .div(cfg_etu_div), .half_tick(half_tick)
    );

    sc_wait_timer #(.WT_W(WT_W)) u_wt (
        .clk(clk), .rst_n(rst_n), .restart(div_restart),
        .half_tick(half_tick), .limit(cfg_wt_limit), .timeout(wt_timeout)
    );

    assign guard_eff = (cfg_guard < GT_W'(MIN_GUARD_ETU)) ? GT_W'(MIN_GUARD_ETU) : cfg_guard;
    assign hold_end  = {1'b0, guard_eff, 1'b0};
    assign hn        = h_q + 1'b1;
    assign dec       = decode_frame(frame_q[9:1], cfg_inverse);

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        h_d         = h_q;
        frame_d     = frame_q;
        retry_d     = retry_q;
        fail_d      = fail_q;
        rep_d       = rep_q;
        div_restart = 1'b0;
        rx_fire     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_valid && io_in) begin            // accept
                    state_d     = ST_TX_BITS;
                    h_d         = '0;
                    frame_d     = encode_frame(tx_data, cfg_inverse);
                    retry_d     = '0;
                    fail_d      = 1'b0;
                    rep_d       = 1'b0;
                    div_restart = 1'b1;
                end else if (!io_in) begin              // start_edge
                    state_d     = ST_RX_BITS;
                    h_d         = '0;
                    div_restart = 1'b1;
                end
            end
            ST_TX_BITS: begin
                if (half_tick) begin
                    h_d = hn;
                    if (hn == H_TX_END) state_d = ST_TX_HOLD; // bits_done
                end
            end
            ST_TX_HOLD: begin
                if (half_tick) begin
                    h_d = hn;
                    if (!cfg_t1 && hn == H_CHK && !io_in) begin
                        if (retry_q < cfg_retry_max) begin
                            rep_d   = 1'b1;
                            retry_d = retry_q + 1'b1;
                        end else begin
                            fail_d  = 1'b1;
                        end
                    end
                    if (hn >= hold_end && io_in) begin
                        if (rep_q) begin                // repeat
                            state_d     = ST_TX_BITS;
                            h_d         = '0;
                            rep_d       = 1'b0;
                            div_restart = 1'b1;
                        end else begin                  // hold_done
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            ST_RX_BITS: begin
                if (half_tick) begin
                    h_d = hn;
                    if (hn == H_QUAL && io_in) begin    // glitch
                        state_d = ST_IDLE;
                    end else if (hn[0] && hn >= H_SMP_LO && hn <= H_SMP_HI) begin
                        frame_d = {io_in, frame_q[9:1]};
                    end else if (hn == H_RX_END) begin
                        if (dec[0] && !cfg_t1) begin
                            state_d = ST_RX_ERR;        // flag_error
                        end else begin
                            state_d = ST_IDLE;          // rx_done
                            rx_fire = 1'b1;
                        end
                    end
                end
            end
            ST_RX_ERR: begin
                if (half_tick) begin
                    h_d = hn;
                    if (hn == H_ERR_END) state_d = ST_IDLE; // flag_done
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            h_q      <= '0;
            frame_q  <= '1;
            retry_q  <= '0;
            fail_q   <= 1'b0;
            rep_q    <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
        end else begin
            state_q  <= state_d;
            h_q      <= h_d;
            frame_q  <= frame_d;
            retry_q  <= retry_d;
            fail_q   <= fail_d;
            rep_q    <= rep_d;
            rx_valid <= rx_fire;
            if (rx_fire) begin
                rx_data <= dec[8:1];
                rx_perr <= dec[0];
            end
        end
    end

    // Outputs
    assign frame_ext = {6'b111111, frame_q};
    always_comb begin
        io_drive_low = 1'b0;
        tx_ready     = 1'b0;
        unique case (state_q)
            ST_IDLE:    tx_ready     = io_in;
            ST_TX_BITS: io_drive_low = ~frame_ext[h_q[4:1]];
            ST_RX_ERR:  io_drive_low = 1'b1;
            default:    io_drive_low = 1'b0;
        endcase
    end
    assign tx_fail = fail_q;

    AST_START_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> io_drive_low) else $error("no start bit"); // R2
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (retry_q <= cfg_retry_max)) else $error("too many repeats"); // R5
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid) else $error("rx_valid longer than one cycle"); // R6
    AST_T1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_t1 && (state_q == ST_RX_BITS || state_q == ST_RX_ERR)) |-> !io_drive_low)
        else $error("line driven while receiving in block protocol"); // R8

endmodule

// File: tb/sim_sc_char_uart.sv
`timescale 1ns/1ps
module sim_sc_char_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_etu_div = 12'd128;
    logic        cfg_inverse = 1'b0;
    logic        cfg_t1 = 1'b1;
    logic [15:0] cfg_guard = 16'd0;
    logic [2:0]  cfg_retry_max = 3'd0;
    logic [31:0] cfg_wt_limit = 32'd0;
    logic        card_low = 1'b0;
    logic        io_in, drv;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, rx_valid, rx_perr, tx_fail, wt_timeout;
    logic [7:0]  rx_data;

    int cyc = 0, checks = 0, failures = 0, rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    logic       rx_last_p = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign io_in = ~(drv | card_low);

    always @(negedge clk) if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
        rx_last_p = rx_perr;
    end

    sc_char_uart u0 (
        .clk(clk), .rst_n(rst_n), .cfg_etu_div(cfg_etu_div), .cfg_inverse(cfg_inverse),
        .cfg_t1(cfg_t1), .cfg_guard(cfg_guard), .cfg_retry_max(cfg_retry_max),
        .cfg_wt_limit(cfg_wt_limit), .io_in(io_in), .io_drive_low(drv),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .tx_fail(tx_fail), .wt_timeout(wt_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Independent model of the line levels: [0] start, then data, then parity
    function automatic logic [9:0] levels(input logic [7:0] b, input logic inv, input logic badp);
        logic [9:0] l;
        logic p;
        l[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            l[i+1] = inv ? ~b[7-i] : b[i];
        end
        p = (^b) ^ badp;
        l[9] = inv ? ~p : p;
        return l;
    endfunction

    task automatic send(input logic [7:0] b, output int t0);
        while (!tx_ready) @(negedge clk);
        tx_data = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        t0 = cyc;
    endtask

    task automatic card_send(input logic [7:0] b, input logic badp, output int c0);
        logic [9:0] l;
        l = levels(b, cfg_inverse, badp);
        c0 = cyc;
        for (int k = 0; k < 10; k++) begin
            card_low = ~l[k];
            repeat (16) @(negedge clk);
        end
        card_low = 1'b0;
    endtask

    task automatic check_tx_frame(input logic [7:0] b, input string req);
        int t0;
        logic [9:0] l;
        l = levels(b, cfg_inverse, 1'b0);
        send(b, t0);
        for (int k = 0; k < 10; k++) begin
            wait_cyc(t0 + 16*k + 8);
            chk(drv == ~l[k], req, drv, ~l[k]);
        end
        wait_cyc(t0 + 168);
        chk(drv == 1'b0, req, drv, 0);
        wait_cyc(t0 + 200);
    endtask

    task automatic t_reset();                      // R10
        chk(drv == 1'b0, "R10 line released", drv, 0);
        chk(tx_ready == 1'b1, "R10 tx_ready", tx_ready, 1);
        chk(rx_valid == 1'b0 && tx_fail == 1'b0 && wt_timeout == 1'b0, "R10 flags clear",
            {rx_valid, tx_fail, wt_timeout}, 0);
    endtask

    task automatic t_tx_direct();                  // R2
        cfg_inverse = 1'b0; cfg_t1 = 1'b1;
        check_tx_frame(8'hA5, "R2 direct A5");
        check_tx_frame(8'h3C, "R2 direct 3C");
    endtask

    task automatic t_tx_inverse();                 // R3
        cfg_inverse = 1'b1; cfg_t1 = 1'b1;
        check_tx_frame(8'h3F, "R3 inverse 3F");
        cfg_inverse = 1'b0;
    endtask

    task automatic t_frac();                       // R1
        int t0;
        cfg_t1 = 1'b1; cfg_etu_div = 12'd93;
        send(8'h00, t0);
        wait_cyc(t0 + 116);
        chk(drv == 1'b1, "R1 11.625 still low", drv, 1);
        wait_cyc(t0 + 117);
        chk(drv == 1'b0, "R1 11.625 released", drv, 0);
        wait_cyc(t0 + 200);
        cfg_etu_div = 12'd128;
        send(8'h00, t0);
        wait_cyc(t0 + 159);
        chk(drv == 1'b1, "R1 16 still low", drv, 1);
        wait_cyc(t0 + 160);
        chk(drv == 1'b0, "R1 16 released", drv, 0);
        wait_cyc(t0 + 200);
    endtask

    task automatic t_guard();                      // R4
        int ta, tb;
        cfg_t1 = 1'b1; cfg_guard = 16'd20;
        send(8'h11, ta);
        send(8'h22, tb);
        chk(tb - ta >= 320 && tb - ta <= 322, "R4 guard 20", tb - ta, 320);
        cfg_guard = 16'd3;
        wait_cyc(tb + 400);
        send(8'h33, ta);
        send(8'h44, tb);
        chk(tb - ta >= 192 && tb - ta <= 194, "R4 guard floor 12", tb - ta, 192);
        wait_cyc(tb + 250);
        cfg_guard = 16'd0;
    endtask

    // Transmit one byte under T=0, flag the first 'nflag' frames; returns frames seen
    task automatic tx_with_flags(input int nflag, output int frames);
        int t;
        bit fin;
        send(8'h96, t);
        frames = 1;
        fin = 1'b0;
        while (!fin) begin
            if (frames <= nflag) begin
                wait_cyc(t + 168);
                card_low = 1'b1;
                wait_cyc(t + 192);
                card_low = 1'b0;
            end else begin
                wait_cyc(t + 192);
            end
            fin = 1'b1;
            for (int i = 0; i < 400; i++) begin
                if (drv) begin
                    frames++;
                    t = cyc;
                    fin = 1'b0;
                    break;
                end
                if (tx_ready) break;
                @(negedge clk);
            end
        end
    endtask

    task automatic t_retry();                      // R5
        int f;
        cfg_t1 = 1'b0;
        cfg_retry_max = 3'd2;
        tx_with_flags(99, f);
        chk(f == 3, "R5 frames with limit 2", f, 3);
        chk(tx_fail == 1'b1, "R5 fail after limit", tx_fail, 1);
        cfg_retry_max = 3'd3;
        tx_with_flags(1, f);
        chk(f == 2, "R5 one repeat", f, 2);
        chk(tx_fail == 1'b0, "R5 fail cleared on accept", tx_fail, 0);
        cfg_retry_max = 3'd0;
        tx_with_flags(99, f);
        chk(f == 1, "R5 limit 0 frames", f, 1);
        chk(tx_fail == 1'b1, "R5 limit 0 fail", tx_fail, 1);
        cfg_t1 = 1'b1;
        wait_cyc(cyc + 50);
    endtask

    task automatic t_rx_good();                    // R6, R3
        int c0, n;
        cfg_t1 = 1'b0; cfg_inverse = 1'b0;
        n = rx_cnt;
        card_send(8'h5A, 1'b0, c0);
        wait_cyc(c0 + 200);
        chk(rx_cnt == n + 1, "R6 one strobe", rx_cnt - n, 1);
        chk(rx_last == 8'h5A && rx_last_p == 1'b0, "R6 byte 5A", rx_last, 8'h5A);
        cfg_inverse = 1'b1; cfg_t1 = 1'b1;
        card_send(8'hC3, 1'b0, c0);
        wait_cyc(c0 + 200);
        chk(rx_last == 8'hC3 && rx_last_p == 1'b0, "R3 inverse rx C3", rx_last, 8'hC3);
        cfg_inverse = 1'b0;
    endtask

    task automatic t_glitch();                     // R6
        int n;
        n = rx_cnt;
        card_low = 1'b1;
        repeat (3) @(negedge clk);
        card_low = 1'b0;
        repeat (40) @(negedge clk);
        chk(rx_cnt == n, "R6 glitch ignored", rx_cnt - n, 0);
        chk(tx_ready == 1'b1 && drv == 1'b0, "R6 idle after glitch", tx_ready, 1);
    endtask

    task automatic t_rx_bad_t0();                  // R7
        int c0, n;
        cfg_t1 = 1'b0;
        n = rx_cnt;
        card_send(8'h0F, 1'b1, c0);
        wait_cyc(c0 + 167);
        chk(drv == 1'b0, "R7 not before 10.5", drv, 0);
        wait_cyc(c0 + 175);
        chk(drv == 1'b1, "R7 error signal", drv, 1);
        wait_cyc(c0 + 192);
        chk(drv == 1'b1, "R7 signal to 12", drv, 1);
        wait_cyc(c0 + 200);
        chk(drv == 1'b0, "R7 released", drv, 0);
        chk(rx_cnt == n, "R7 no strobe", rx_cnt - n, 0);
        cfg_t1 = 1'b1;
    endtask

    task automatic t_rx_bad_t1();                  // R8
        int c0, n;
        cfg_t1 = 1'b1;
        n = rx_cnt;
        card_send(8'h81, 1'b1, c0);
        wait_cyc(c0 + 175);
        chk(drv == 1'b0, "R8 no error signal", drv, 0);
        wait_cyc(c0 + 200);
        chk(rx_cnt == n + 1 && rx_last_p == 1'b1, "R8 perr reported", rx_last_p, 1);
        chk(rx_last == 8'h81, "R8 byte kept", rx_last, 8'h81);
    endtask

    task automatic t_wait();                       // R9
        int t0;
        cfg_t1 = 1'b1; cfg_wt_limit = 32'd5;
        send(8'h77, t0);
        wait_cyc(t0 + 76);
        chk(wt_timeout == 1'b0, "R9 before limit", wt_timeout, 0);
        wait_cyc(t0 + 84);
        chk(wt_timeout == 1'b1, "R9 at limit", wt_timeout, 1);
        wait_cyc(t0 + 300);
        chk(wt_timeout == 1'b1, "R9 stays", wt_timeout, 1);
        send(8'h78, t0);
        wait_cyc(t0 + 8);
        chk(wt_timeout == 1'b0, "R9 cleared by start", wt_timeout, 0);
        wait_cyc(t0 + 250);
        cfg_wt_limit = 32'd0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_tx_direct();
        t_tx_inverse();
        t_frac();
        t_guard();
        t_retry();
        t_rx_good();
        t_glitch();
        t_rx_bad_t0();
        t_rx_bad_t1();
        t_wait();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule